// File: doc/BRIEF.md
# Frame-Aligned Two-Lane Serial Sample Deserializer

This block receives the serial output of a multi-channel data converter. Each channel sends its 12-bit samples over two serial lanes. The link also carries a bit clock and a frame signal. Outside logic captures each lane, and the frame signal, on both edges of the bit clock. It hands the block two bits per bit-clock cycle; the bit taken on the rising edge comes first.

The block treats the frame signal as one more data lane. It keeps a short history of the frame bits, of every lane, and finds the point where each sample word ends. It then rebuilds one 12-bit sample per channel and passes all channels of that instant, as one entry, through an 8-entry asynchronous FIFO into the system clock domain. One instance serves one bit-clock and frame-signal pair. A design with several converters instantiates the block once per pair.

The system-side output is a valid/ready stream. An entry is transferred on a system-clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, `out_valid` and `out_data` hold their values. The block cannot stall the converter. If a word completes while the FIFO is full, that word is dropped and `overflow` is set.

Top module: `adc_frame_deser`

## Requirements
- R1: Each sample takes 3 bit-clock cycles, or 6 bit slots, per lane. Lane 1 carries the odd sample bits and lane 0 the even bits, and the highest pair (bits 11 and 10) arrives first. In each input pair, bit 1 is the earlier (rising-edge) slot. Channel c uses `lane_in[4c+1:4c]` for lane 0 and `lane_in[4c+3:4c+2]` for lane 1, and its sample appears at `out_data[12c+11:12c]`.
- R2: A word ends at a bit slot when the 7 most recent frame slots up to and including that slot read 0,1,1,1,0,0,0 from oldest to newest. A word may end on either slot of a bit-clock pair, which gives two possible bit offsets.
- R3: While unlocked, `locked` rises when 4 consecutive word ends are found at the same offset, each exactly 3 bit-clock cycles after the previous one. The word that completes the fourth is the first word emitted.
- R4: While unlocked, no word is written to the FIFO.
- R5: While locked, a word is emitted at every expected boundary, exactly 3 bit-clock cycles apart, taken at the locked offset. This holds even when the frame pattern fails to match there, as long as fewer than 4 consecutive misses have occurred. Matches found at the other offset are ignored.
- R6: On the 4th consecutive miss, `locked` falls and that word is not emitted. Acquisition then starts over from nothing, and may settle on a new offset.
- R7: Words leave the FIFO in the order they were completed, none duplicated or invented. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable.
- R8: The FIFO holds 8 entries. A word completed while the FIFO is full is discarded and sets `overflow`, which stays set until `bit_rst`.
- R9: Asserting `bit_rst` and `sys_rst` together clears the lock state, the history registers, `overflow` and every word still held, so that `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Converter bit clock, capture clock of all lanes |
| bit_rst | input | 1 | Synchronous reset, bit-clock domain |
| frm_in | input | 2 | Frame signal slot pair, bit 1 earlier |
| lane_in | input | NUM_CH*4 | Two lanes per channel, each a slot pair |
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous reset, system-clock domain |
| out_valid | output | 1 | FIFO output holds a word |
| out_ready | input | 1 | Consumer accepts the word this edge |
| out_data | output | NUM_CH*12 | One sample per channel |
| locked | output | 1 | Word alignment established (bit-clock domain) |
| overflow | output | 1 | Sticky: a word was lost to a full FIFO |

## Verification
The bench starts the stream on both bit offsets. If the offset is chosen wrongly, or the two lanes or the two slots of a pair are swapped, every sample comes out scrambled. It breaks the frame pattern for three frames and then for four. A design with the miss limit off by one either drops lock too early or emits the fourth bad word. A bit slip while locked must be followed by a stale-offset flywheel, then loss of lock and re-acquisition at the new offset; a design that jumped offsets early would misalign words. A burst with no reads checks that exactly the first 8 words survive, which exposes an off-by-one in the full test.

// File: rtl/adf_pkg.sv
package adf_pkg;
  // Alignment machine: searching for a stable boundary, or tracking one.
  typedef enum logic {ST_HUNT, ST_TRACK} align_st_t;
  // Bits delivered per lane per bit-clock cycle (both clock edges).
  localparam int SLOTS_PER_CLK = 2;
endpackage

// File: rtl/adf_lane_shift.sv
// History register for one double-edge lane: two slots shift in per cycle,
// newest slot lands in bit 0, the earlier (rising-edge) slot in bit 1.
module adf_lane_shift
  import adf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SLOTS_PER_CLK-1:0] pair_in,
  output logic [W-1:0]             hist
);
  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[W-SLOTS_PER_CLK-1:0], pair_in[1], pair_in[0]};
  end
endmodule

// File: rtl/adf_frame_align.sv
// Finds word ends in the frame history, runs the lock machine and
// reassembles one sample per channel from the interleaved lane histories.
module adf_frame_align
  import adf_pkg::*;
#(
  parameter  int NUM_CH      = 2,
  parameter  int SAMPLE_W    = 12,
  parameter  int LOCK_FRAMES = 4,
  parameter  int MISS_LIMIT  = 4,
  localparam int BPL         = SAMPLE_W / 2,
  localparam int FHW         = BPL + 2,
  localparam int LHW         = BPL + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [FHW-1:0]             fhist,
  input  logic [NUM_CH*LHW-1:0]      l0hist,
  input  logic [NUM_CH*LHW-1:0]      l1hist,
  output logic                       locked,
  output logic                       wr_vld,
  output logic [NUM_CH*SAMPLE_W-1:0] wr_word
);
  localparam int WC = BPL / SLOTS_PER_CLK;          // bit-clock cycles per word
  localparam int HALF = BPL / 2;                    // frame high slots
  localparam int PW = $clog2(WC + 1);
  localparam int GW = $clog2(LOCK_FRAMES + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam logic [BPL:0] PAT = (BPL + 1)'(((1 << HALF) - 1) << HALF);
  localparam logic [PW-1:0] PH_LAST = PW'(WC - 1);

  align_st_t     st, st_n;
  logic          off, off_n, sel;
  logic [PW-1:0] ph, ph_n;
  logic [GW-1:0] g, g_n;
  logic [MW-1:0] m, m_n;
  logic          hit0, hit1, hit_k, emit;
  logic [NUM_CH*SAMPLE_W-1:0] word_n;

  assign hit0  = (fhist[BPL:0] == PAT);
  assign hit1  = (fhist[BPL+1:1] == PAT);
  assign hit_k = hit1 & ~hit0;

  always_comb begin
    st_n = st; off_n = off; ph_n = ph; g_n = g; m_n = m; emit = 1'b0;
    if (st == ST_HUNT) begin
      if (hit0 || hit1) begin
        ph_n  = '0;
        off_n = hit_k;
        if (g != '0 && ph == PH_LAST && off == hit_k) g_n = g + 1'b1;
        else                                          g_n = GW'(1);
        if (g_n == GW'(LOCK_FRAMES)) begin
          st_n = ST_TRACK;
          m_n  = '0;
          emit = 1'b1;
        end
      end else if (ph == PH_LAST) begin
        g_n = '0;
      end else begin
        ph_n = ph + 1'b1;
      end
    end else begin
      if (ph == PH_LAST) begin
        ph_n = '0;
        if (off ? hit1 : hit0) begin
          m_n  = '0;
          emit = 1'b1;
        end else if (m == MW'(MISS_LIMIT - 1)) begin
          st_n = ST_HUNT;
          g_n  = '0;
          m_n  = '0;
          ph_n = PH_LAST;
        end else begin
          m_n  = m + 1'b1;
          emit = 1'b1;
        end
      end else begin
        ph_n = ph + 1'b1;
      end
    end
  end

  // Lane 1 supplies odd bits, lane 0 even bits; older slots are more significant.
  assign sel = (st == ST_TRACK) ? off : off_n;
  always_comb begin
    word_n = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int i = 0; i < BPL; i++) begin
        word_n[c*SAMPLE_W + 2*i]     = l0hist[c*LHW + i + int'(sel)];
        word_n[c*SAMPLE_W + 2*i + 1] = l1hist[c*LHW + i + int'(sel)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_HUNT; off <= 1'b0; ph <= '0; g <= '0; m <= '0;
      wr_vld <= 1'b0; wr_word <= '0;
    end else begin
      st <= st_n; off <= off_n; ph <= ph_n; g <= g_n; m <= m_n;
      wr_vld <= emit;
      if (emit) wr_word <= word_n;
    end
  end

  assign locked = (st == ST_TRACK);
endmodule

// File: rtl/adf_async_fifo.sv
// Dual-clock FIFO with Gray-coded pointers and two-flop synchronizers.
module adf_async_fifo #(
  parameter  int W  = 24,
  parameter  int AW = 3,
  localparam int D  = 1 << AW
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         wen,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst,
  output logic         rvalid,
  input  logic         rready,
  output logic [W-1:0] rdata
);
  logic [W-1:0] mem [D];
  logic [AW:0] wbin, wgray, rbin, rgray, rq1, rq2, wq1, wq2;
  logic [AW:0] wbin_n, rbin_n;
  logic        wdo, rdo;

  assign wbin_n = wbin + 1'b1;
  assign rbin_n = rbin + 1'b1;
  assign full   = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
  assign rvalid = (rgray != wq2);
  assign wdo    = wen && !full;
  assign rdo    = rvalid && rready;
  assign rdata  = mem[rbin[AW-1:0]];

  always_ff @(posedge wclk) begin
    if (wdo) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wdo) begin
        wbin  <= wbin_n;
        wgray <= wbin_n ^ (wbin_n >> 1);
      end
    end
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (rdo) begin
        rbin  <= rbin_n;
        rgray <= rbin_n ^ (rbin_n >> 1);
      end
    end
  end
endmodule

// File: rtl/adc_frame_deser.sv
module adc_frame_deser #(
  parameter int NUM_CH      = 2,
  parameter int SAMPLE_W    = 12,
  parameter int LOCK_FRAMES = 4,
  parameter int MISS_LIMIT  = 4,
  parameter int FIFO_AW     = 3
) (
  input  logic                       bit_clk,
  input  logic                       bit_rst,
  input  logic [1:0]                 frm_in,
  input  logic [NUM_CH*4-1:0]        lane_in,
  input  logic                       sys_clk,
  input  logic                       sys_rst,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [NUM_CH*SAMPLE_W-1:0] out_data,
  output logic                       locked,
  output logic                       overflow
);
  localparam int BPL = SAMPLE_W / 2;
  localparam int FHW = BPL + 2;
  localparam int LHW = BPL + 1;
  localparam int DW  = NUM_CH * SAMPLE_W;

  logic [FHW-1:0]        fhist;
  logic [NUM_CH*LHW-1:0] l0hist, l1hist;
  logic                  wr_vld, fifo_full;
  logic [DW-1:0]         wr_word;

  adf_lane_shift #(.W(FHW)) u_fsh (
    .clk(bit_clk), .rst(bit_rst), .pair_in(frm_in), .hist(fhist)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    adf_lane_shift #(.W(LHW)) u_l0 (
      .clk(bit_clk), .rst(bit_rst), .pair_in(lane_in[4*c +: 2]),
      .hist(l0hist[c*LHW +: LHW])
    );
    adf_lane_shift #(.W(LHW)) u_l1 (
      .clk(bit_clk), .rst(bit_rst), .pair_in(lane_in[4*c+2 +: 2]),
      .hist(l1hist[c*LHW +: LHW])
    );
  end

  adf_frame_align #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W),
    .LOCK_FRAMES(LOCK_FRAMES), .MISS_LIMIT(MISS_LIMIT)
  ) u_align (
    .clk(bit_clk), .rst(bit_rst), .fhist(fhist), .l0hist(l0hist),
    .l1hist(l1hist), .locked(locked), .wr_vld(wr_vld), .wr_word(wr_word)
  );

  adf_async_fifo #(.W(DW), .AW(FIFO_AW)) u_fifo (
    .wclk(bit_clk), .wrst(bit_rst), .wen(wr_vld), .wdata(wr_word),
    .full(fifo_full), .rclk(sys_clk), .rrst(sys_rst),
    .rvalid(out_valid), .rready(out_ready), .rdata(out_data)
  );

  always_ff @(posedge bit_clk) begin
    if (bit_rst)                    overflow <= 1'b0;
    else if (wr_vld && fifo_full)   overflow <= 1'b1;
  end
endmodule

// File: rtl/adf_chk.sv
module adf_chk #(
  parameter int DW = 24
) (
  input logic          bit_clk,
  input logic          bit_rst,
  input logic          sys_clk,
  input logic          sys_rst,
  input logic          locked,
  input logic          wr_vld,
  input logic          overflow,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  // R4
  no_word_unlocked_chk: assert property (@(posedge bit_clk) disable iff (bit_rst)
    wr_vld |-> locked);

  // R3
  lock_emits_first_chk: assert property (@(posedge bit_clk) disable iff (bit_rst)
    $rose(locked) |-> wr_vld);

  // R5
  word_spacing_chk: assert property (@(posedge bit_clk) disable iff (bit_rst)
    wr_vld |=> !wr_vld ##1 !wr_vld);

  // R8
  overflow_sticky_chk: assert property (@(posedge bit_clk) disable iff (bit_rst)
    overflow |=> overflow);

  // R7
  hold_stall_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  reset_clear_chk: assert property (@(posedge bit_clk)
    bit_rst |=> (!locked && !overflow));
endmodule

bind adc_frame_deser adf_chk #(.DW(NUM_CH*SAMPLE_W)) u_chk (
  .bit_clk(bit_clk), .bit_rst(bit_rst), .sys_clk(sys_clk), .sys_rst(sys_rst),
  .locked(locked), .wr_vld(wr_vld), .overflow(overflow),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/adc_frame_deser_test.sv
module adc_frame_deser_test;
  localparam int NCH = 2;
  localparam int MH  = 8;

  logic        bit_clk = 0, sys_clk = 0;
  logic        bit_rst = 1, sys_rst = 1;
  logic [1:0]  frm_in = 0;
  logic [7:0]  lane_in = 0;
  logic        out_ready = 0;
  logic        out_valid, locked, overflow;
  logic [23:0] out_data;

  adc_frame_deser uut (
    .bit_clk(bit_clk), .bit_rst(bit_rst), .frm_in(frm_in), .lane_in(lane_in),
    .sys_clk(sys_clk), .sys_rst(sys_rst), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .locked(locked),
    .overflow(overflow)
  );

  always #5  sys_clk = ~sys_clk;
  always #13 bit_clk = ~bit_clk;

  int total = 0, bad = 0, cyc = 0;
  int rst_cnt = 6;
  int ready_mode = 0;       // 0 always ready, 1 random, 2 never
  int cap_mode = 0, cap_used = 0, popped = 0;

  // slot: {frame, ch1 lane1, ch1 lane0, ch0 lane1, ch0 lane0}
  logic [4:0]  slotq[$];
  logic [23:0] expq[$];

  // reference model state
  logic [4:0] mh[MH];
  int  m_lock, m_off, m_ph, m_g, m_m;
  logic lk1 = 0, lk2 = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_frame(input logic [11:0] w0, input logic [11:0] w1,
                            input bit good);
    for (int t = 0; t < 6; t++) begin
      logic f;
      f = good ? (t < 3) : 1'b0;
      slotq.push_back({f, w1[11-2*t], w1[10-2*t], w0[11-2*t], w0[10-2*t]});
    end
  endtask

  task automatic push_good(input int n);
    for (int i = 0; i < n; i++)
      push_frame(12'($urandom), 12'($urandom), 1'b1);
  endtask

  task automatic push_bad(input int n);
    for (int i = 0; i < n; i++)
      push_frame(12'($urandom), 12'($urandom), 1'b0);
  endtask

  function automatic bit frame_end(input int k);
    bit ok;
    ok = (mh[k+6][4] == 1'b0);
    for (int j = 3; j <= 5; j++) ok = ok && (mh[k+j][4] == 1'b1);
    for (int j = 0; j <= 2; j++) ok = ok && (mh[k+j][4] == 1'b0);
    return ok;
  endfunction

  task automatic model_emit(input int k);
    logic [11:0] w0, w1;
    for (int t = 0; t < 6; t++) begin
      logic [4:0] s;
      s = mh[k+5-t];
      w0[11-2*t] = s[1]; w0[10-2*t] = s[0];
      w1[11-2*t] = s[3]; w1[10-2*t] = s[2];
    end
    if (cap_mode == 0) expq.push_back({w1, w0});
    else if (cap_used < 8) begin
      expq.push_back({w1, w0});
      cap_used++;
    end
  endtask

  task automatic model_step(input logic [4:0] s0, input logic [4:0] s1);
    bit e0, e1, any;
    int k;
    for (int j = MH-1; j >= 2; j--) mh[j] = mh[j-2];
    mh[1] = s0;
    mh[0] = s1;
    e0 = frame_end(0);
    e1 = frame_end(1);
    any = e0 || e1;
    k = e0 ? 0 : 1;
    if (m_lock == 0) begin
      if (any) begin
        if (m_g > 0 && m_ph == 2 && m_off == k) m_g++;
        else m_g = 1;
        m_off = k;
        m_ph = 0;
        if (m_g == 4) begin m_lock = 1; m_m = 0; model_emit(k); end
      end else if (m_ph == 2) m_g = 0;
      else m_ph++;
    end else if (m_ph != 2) begin
      m_ph++;
    end else begin
      m_ph = 0;
      if ((m_off == 0) ? e0 : e1) begin m_m = 0; model_emit(m_off); end
      else if (m_m == 3) begin m_lock = 0; m_g = 0; m_m = 0; m_ph = 2; end
      else begin m_m++; model_emit(m_off); end
    end
  endtask

  task automatic model_reset();
    for (int j = 0; j < MH; j++) mh[j] = '0;
    m_lock = 0; m_off = 0; m_ph = 0; m_g = 0; m_m = 0;
    lk1 = 0; lk2 = 0;
  endtask

  // bit-clock side: drive slots, step the model, compare lock (two edges later)
  always @(negedge bit_clk) begin
    if (rst_cnt > 0) begin
      bit_rst = 1; frm_in = 0; lane_in = 0;
      slotq.delete(); expq.delete();
      model_reset();
      rst_cnt--;
    end else begin
      logic [4:0] s0, s1;
      bit_rst = 0;
      chk(locked == lk2, "R3/R6", "lock", locked, lk2);
      s0 = (slotq.size() > 0) ? slotq.pop_front() : 5'd0;
      s1 = (slotq.size() > 0) ? slotq.pop_front() : 5'd0;
      frm_in = {s0[4], s1[4]};
      for (int c = 0; c < NCH; c++) begin
        lane_in[4*c+1] = s0[2*c];   lane_in[4*c]   = s1[2*c];
        lane_in[4*c+3] = s0[2*c+1]; lane_in[4*c+2] = s1[2*c+1];
      end
      model_step(s0, s1);
      lk2 = lk1;
      lk1 = logic'(m_lock);
    end
  end

  // system side: choose ready, compare every accepted word
  always @(negedge sys_clk) begin
    sys_rst = bit_rst;
    case (ready_mode)
      0: out_ready = 1;
      1: out_ready = 1'($urandom);
      default: out_ready = 0;
    endcase
    if (!sys_rst && out_valid && out_ready) begin
      popped++;
      if (expq.size() == 0)
        chk(0, "R7", "unexpected word", out_data, 0);
      else begin
        logic [23:0] e;
        e = expq.pop_front();
        chk(out_data == e, "R1/R7", "word", out_data, e);
      end
    end
  end

  always @(posedge sys_clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge bit_clk);
    rst_cnt = 6;
    wait (rst_cnt == 0);
    repeat (3) @(negedge bit_clk);
  endtask

  task automatic finish_phase(input string req);
    wait (slotq.size() == 0);
    repeat (20) @(negedge bit_clk);
    for (int i = 0; i < 2000 && expq.size() > 0; i++) @(negedge sys_clk);
    repeat (10) @(negedge sys_clk);
    chk(expq.size() == 0, req, "words left undelivered", expq.size(), 0);
  endtask

  initial begin
    wait (rst_cnt == 0);
    repeat (3) @(negedge bit_clk);
    // R9: reset state
    chk(locked == 0, "R9", "lock after reset", locked, 0);
    chk(out_valid == 0, "R9", "valid after reset", out_valid, 0);
    chk(overflow == 0, "R9", "overflow after reset", overflow, 0);

    // R1 R2 R3 R4: aligned start, offset 0
    ready_mode = 0;
    push_good(10);
    finish_phase("R1");
    chk(overflow == 0, "R8", "overflow with ready", overflow, 0);

    // R2: start on the other slot of a pair, random back-pressure
    do_reset();
    ready_mode = 1;
    slotq.push_back(5'd0);
    push_good(12);
    finish_phase("R2");

    // R5 R6: three bad frames keep lock, four drop it, then re-acquire
    do_reset();
    push_good(6); push_bad(3); push_good(4); push_bad(4); push_good(6);
    finish_phase("R5");

    // R6: one-slot slip while locked
    do_reset();
    push_good(6);
    slotq.push_back(5'd0);
    push_good(10);
    finish_phase("R6");
    chk(overflow == 0, "R8", "overflow with back-pressure", overflow, 0);

    // R8: burst with no reads
    do_reset();
    ready_mode = 2;
    cap_mode = 1;
    cap_used = 0;
    push_good(14);
    wait (slotq.size() == 0);
    repeat (20) @(negedge bit_clk);
    chk(overflow == 1, "R8", "overflow after burst", overflow, 1);
    @(negedge sys_clk);
    chk(out_valid == 1, "R8", "full fifo valid", out_valid, 1);
    popped = 0;
    ready_mode = 1;
    finish_phase("R8");
    chk(popped == 8, "R8", "words kept", popped, 8);
    chk(overflow == 1, "R8", "overflow sticky", overflow, 1);

    // R9: reset clears sticky flag and lock
    cap_mode = 0;
    do_reset();
    chk(overflow == 0, "R9", "overflow cleared", overflow, 0);
    chk(locked == 0, "R9", "lock cleared", locked, 0);
    chk(out_valid == 0, "R9", "fifo emptied", out_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule